// File: doc/BRIEF.md
# Data-Space Router with Core Special Registers

This block sits between a small processor core's load/store unit and the places a byte of data space can live. Each request carries one address in a single flat data space. The block sends it to one of three regions. The lowest addresses reach the general register file. The next window reaches I/O space. Everything above that goes to data memory. Write data leaving the block is always cut to one byte, whatever the width of the request bus.

Inside the I/O window, the top eight ports belong to the core and are held in this block instead of on the peripheral bus:

- four extended-address page registers, each with its own feature enable;
- an indirect-jump extension register;
- the two bytes of the stack pointer;
- an 8-bit status register.

The page and jump-extension values are presented already shifted into bits 23:16 of a 24-bit word, ready to be joined to a 16-bit pointer. Reads complete in one cycle through a registered output.

Top module: `dspace_router`

## Requirements
- R1: A data address below 32 goes to the register file. A write raises `rf_we` with `rf_addr` equal to the address. A read returns `rf_rdata` on `cpu_rdata`. No I/O or memory strobe fires.
- R2: Addresses 32 to 95 that are not special ports go to the I/O bus. The bus address is `io_addr = IO_BASE + (address - 32)`, with IO_BASE = 32 by default. A read returns `io_rdata`.
- R3: Addresses of 96 and above go to memory with `mem_addr` equal to the address. A read returns `mem_rdata`. No other strobe fires.
- R4: Every outgoing write byte (`rf_wdata`, `io_wdata`, `mem_wdata`, and the special registers) is `cpu_wdata[7:0]`. Higher data bits have no effect.
- R5: The page registers sit at data addresses 0x58, 0x59, 0x5A and 0x5B (D, X, Y, Z). Each holds its written byte in bits 23:16 of its 24-bit output, with bits 15:0 at zero. A read returns that byte.
- R6: A write to a page register takes effect only when its `cfg_page_en` bit is set: bit 0 for D, bit 1 for X, bit 2 for Y, bit 3 for Z. Otherwise the write is ignored.
- R7: The jump-extension register at 0x5C takes every write. It holds the byte in bits 23:16 of `jump_ext`, and a read returns that byte.
- R8: A write to 0x5D replaces `sp[7:0]` and keeps `sp[15:8]`. A read of 0x5D returns `sp[7:0]`.
- R9: A write to 0x5E sets `sp[15:8]` only when `cfg_sp_wide` is 1, and is ignored otherwise. A read of 0x5E returns `sp[15:8]`.
- R10: A write to 0x5F stores the byte as eight flags, with bit 7 down to bit 0 being I, T, H, S, V, N, Z, C. `status` and a read of 0x5F return the same eight bits in that order.
- R11: Requests to 0x58 to 0x5F never raise `rf_we`, `io_rd`, `io_wr`, `mem_rd` or `mem_wr`.
- R12: A read request is answered in the next cycle, when `cpu_rvalid` is 1 and `cpu_rdata` holds the data. A read and a write to the same special port in one cycle return the value from before the write.
- R13: After reset, all page, jump, stack and status state is zero and `cpu_rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_page_en | input | 4 | Write enables for page registers D, X, Y, Z |
| cfg_sp_wide | input | 1 | Stack pointer high byte is writable |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| cpu_addr | input | ADDR_W | Data-space address |
| cpu_wdata | input | CPU_DW | Write data (low byte used) |
| cpu_rdata | output | 8 | Registered read data |
| cpu_rvalid | output | 1 | Read data valid |
| rf_we | output | 1 | Register file write enable |
| rf_addr | output | 5 | Register file index |
| rf_wdata | output | 8 | Register file write byte |
| rf_rdata | input | 8 | Register file read byte |
| io_rd | output | 1 | I/O bus read strobe |
| io_wr | output | 1 | I/O bus write strobe |
| io_addr | output | IO_ADDR_W | I/O bus address |
| io_wdata | output | 8 | I/O bus write byte |
| io_rdata | input | 8 | I/O bus read byte |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| page_d | output | EXT_W | Page register D, byte in top bits |
| page_x | output | EXT_W | Page register X, byte in top bits |
| page_y | output | EXT_W | Page register Y, byte in top bits |
| page_z | output | EXT_W | Page register Z, byte in top bits |
| jump_ext | output | EXT_W | Jump extension, byte in top bits |
| sp | output | 16 | Stack pointer |
| status | output | 8 | Status flags I,T,H,S,V,N,Z,C |

## Verification
A read and a write can hit the same special register in the same cycle. The registered read mux then has to pick up the state before the write commits. The bench provokes this by asserting `cpu_rd` and `cpu_wr` together on the stack-pointer low byte with a new value. It expects the old byte on `cpu_rdata` one cycle later, then the new byte on a following read, with the high byte unchanged. The second overlap is a feature-gated write landing on a register whose enable is off. The bench checks that the stored value survives, both at the output port and by reading it back.

// File: rtl/ds_pkg.sv
package ds_pkg;
   localparam int unsigned BYTE_W       = 8;
   localparam int unsigned NUM_PAGE     = 4;
   localparam int unsigned SPECIAL_PORT = 'h38;
   localparam int unsigned SP_W         = 16;

   typedef enum logic [1:0] {
      REG_GPR = 2'd0,
      REG_IO  = 2'd1,
      REG_MEM = 2'd2
   } region_e;

   // index of a core-local port relative to SPECIAL_PORT; order is address order
   typedef enum logic [2:0] {
      SPC_PAGE_D = 3'd0,
      SPC_PAGE_X = 3'd1,
      SPC_PAGE_Y = 3'd2,
      SPC_PAGE_Z = 3'd3,
      SPC_JEXT   = 3'd4,
      SPC_SP_LO  = 3'd5,
      SPC_SP_HI  = 3'd6,
      SPC_STAT   = 3'd7
   } spec_e;

   typedef enum logic [1:0] {
      SRC_GPR  = 2'd0,
      SRC_IO   = 2'd1,
      SRC_SPEC = 2'd2,
      SRC_MEM  = 2'd3
   } src_e;

   typedef struct packed {
      logic f_i;
      logic f_t;
      logic f_h;
      logic f_s;
      logic f_v;
      logic f_n;
      logic f_z;
      logic f_c;
   } status_t;
endpackage

// File: rtl/ds_range_decode.sv
module ds_range_decode
   import ds_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned GPR_COUNT = 32,
   parameter int unsigned IO_COUNT  = 64,
   localparam int unsigned PORT_W   = $clog2(IO_COUNT)
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [PORT_W-1:0] port,
   output logic              is_spec,
   output spec_e             spec_sel
);
   localparam logic [ADDR_W-1:0]   IO_LO   = ADDR_W'(GPR_COUNT);
   localparam logic [ADDR_W-1:0]   MEM_LO  = ADDR_W'(GPR_COUNT + IO_COUNT);
   localparam logic [PORT_W-4:0]   SPEC_HI = (PORT_W-3)'(SPECIAL_PORT >> 3);

   logic [ADDR_W-1:0] off;
   logic              unused_off_hi;

   always_comb begin
      if (addr < IO_LO)       region = REG_GPR;
      else if (addr < MEM_LO) region = REG_IO;
      else                    region = REG_MEM;
   end

   assign off           = addr - IO_LO;
   assign port          = off[PORT_W-1:0];
   assign unused_off_hi = ^off[ADDR_W-1:PORT_W];
   assign is_spec       = (region == REG_IO) && (port[PORT_W-1:3] == SPEC_HI);
   assign spec_sel      = spec_e'(port[2:0]);
endmodule

// File: rtl/ds_special_regs.sv
module ds_special_regs
   import ds_pkg::*;
#(
   parameter int unsigned EXT_W = 24
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  spec_e                           spec_sel,
   input  logic [BYTE_W-1:0]               wbyte,
   input  logic [NUM_PAGE-1:0]             cfg_page_en,
   input  logic                            cfg_sp_wide,
   output logic [NUM_PAGE-1:0][EXT_W-1:0]  page_q,
   output logic [EXT_W-1:0]                jext_q,
   output logic [SP_W-1:0]                 sp_q,
   output status_t                         stat_q,
   output logic [BYTE_W-1:0]               rd_byte
);
   localparam int unsigned PAD_W = EXT_W - BYTE_W;

   logic [NUM_PAGE-1:0][BYTE_W-1:0] page_byte;
   logic [BYTE_W-1:0]               jext_byte;

   for (genvar g = 0; g < NUM_PAGE; g++) begin : g_page
      logic hit;
      assign hit = wr_en && (spec_sel == spec_e'(g)) && cfg_page_en[g];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   page_byte[g] <= '0;
         else if (hit) page_byte[g] <= wbyte;
      end
      assign page_q[g] = {page_byte[g], {PAD_W{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         jext_byte <= '0;
         sp_q      <= '0;
         stat_q    <= '0;
      end else if (wr_en) begin
         unique case (spec_sel)
            SPC_JEXT:  jext_byte  <= wbyte;
            SPC_SP_LO: sp_q[7:0]  <= wbyte;
            SPC_SP_HI: if (cfg_sp_wide) sp_q[15:8] <= wbyte;
            SPC_STAT:  stat_q     <= status_t'(wbyte);
            default:   ;
         endcase
      end
   end

   assign jext_q = {jext_byte, {PAD_W{1'b0}}};

   always_comb begin
      unique case (spec_sel)
         SPC_PAGE_D, SPC_PAGE_X,
         SPC_PAGE_Y, SPC_PAGE_Z: rd_byte = page_byte[spec_sel[1:0]];
         SPC_JEXT:               rd_byte = jext_byte;
         SPC_SP_LO:              rd_byte = sp_q[7:0];
         SPC_SP_HI:              rd_byte = sp_q[15:8];
         default:                rd_byte = stat_q;
      endcase
   end
endmodule

// File: rtl/ds_read_port.sv
module ds_read_port
   import ds_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  region_e           region,
   input  logic              is_spec,
   input  logic [BYTE_W-1:0] gpr_byte,
   input  logic [BYTE_W-1:0] io_byte,
   input  logic [BYTE_W-1:0] spec_byte,
   input  logic [BYTE_W-1:0] mem_byte,
   output logic [BYTE_W-1:0] rdata_q,
   output logic              rvalid_q
);
   src_e              src;
   logic [BYTE_W-1:0] pick;

   always_comb begin
      unique case (region)
         REG_GPR: src = SRC_GPR;
         REG_IO:  src = is_spec ? SRC_SPEC : SRC_IO;
         default: src = SRC_MEM;
      endcase
   end

   always_comb begin
      unique case (src)
         SRC_GPR:  pick = gpr_byte;
         SRC_IO:   pick = io_byte;
         SRC_SPEC: pick = spec_byte;
         default:  pick = mem_byte;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= rd_en;
         if (rd_en) rdata_q <= pick;
      end
   end
endmodule

// File: rtl/dspace_router.sv
module dspace_router
   import ds_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned CPU_DW    = 16,
   parameter int unsigned GPR_COUNT = 32,
   parameter int unsigned IO_COUNT  = 64,
   parameter int unsigned IO_ADDR_W = 16,
   parameter int unsigned IO_BASE   = 32,
   parameter int unsigned EXT_W     = 24,
   localparam int unsigned RF_AW    = $clog2(GPR_COUNT),
   localparam int unsigned PORT_W   = $clog2(IO_COUNT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PAGE-1:0]  cfg_page_en,
   input  logic                 cfg_sp_wide,
   input  logic                 cpu_rd,
   input  logic                 cpu_wr,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic [CPU_DW-1:0]    cpu_wdata,
   output logic [BYTE_W-1:0]    cpu_rdata,
   output logic                 cpu_rvalid,
   output logic                 rf_we,
   output logic [RF_AW-1:0]     rf_addr,
   output logic [BYTE_W-1:0]    rf_wdata,
   input  logic [BYTE_W-1:0]    rf_rdata,
   output logic                 io_rd,
   output logic                 io_wr,
   output logic [IO_ADDR_W-1:0] io_addr,
   output logic [BYTE_W-1:0]    io_wdata,
   input  logic [BYTE_W-1:0]    io_rdata,
   output logic                 mem_rd,
   output logic                 mem_wr,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [BYTE_W-1:0]    mem_wdata,
   input  logic [BYTE_W-1:0]    mem_rdata,
   output logic [EXT_W-1:0]     page_d,
   output logic [EXT_W-1:0]     page_x,
   output logic [EXT_W-1:0]     page_y,
   output logic [EXT_W-1:0]     page_z,
   output logic [EXT_W-1:0]     jump_ext,
   output logic [SP_W-1:0]      sp,
   output logic [BYTE_W-1:0]    status
);
   if (GPR_COUNT != (1 << RF_AW)) begin : g_chk_gpr
      $error("GPR_COUNT must be a power of two");
   end
   if (IO_COUNT < 64 || IO_COUNT != (1 << PORT_W)) begin : g_chk_io
      $error("IO_COUNT must be a power of two of at least 64");
   end
   if (GPR_COUNT + IO_COUNT >= (1 << ADDR_W)) begin : g_chk_addr
      $error("ADDR_W too small for register and I/O windows");
   end
   if (CPU_DW <= BYTE_W || EXT_W <= BYTE_W || IO_ADDR_W <= PORT_W) begin : g_chk_w
      $error("CPU_DW, EXT_W and IO_ADDR_W must exceed their byte or port width");
   end

   region_e                        region;
   logic [PORT_W-1:0]              port;
   logic                           is_spec;
   spec_e                          spec_sel;
   logic [BYTE_W-1:0]              wbyte;
   logic [BYTE_W-1:0]              spec_byte;
   logic [NUM_PAGE-1:0][EXT_W-1:0] page_q;
   status_t                        stat_q;
   logic                           unused_wdata_hi;

   ds_range_decode #(
      .ADDR_W   (ADDR_W),
      .GPR_COUNT(GPR_COUNT),
      .IO_COUNT (IO_COUNT)
   ) u_decode (
      .addr    (cpu_addr),
      .region  (region),
      .port    (port),
      .is_spec (is_spec),
      .spec_sel(spec_sel)
   );

   assign wbyte           = cpu_wdata[BYTE_W-1:0];
   assign unused_wdata_hi = ^cpu_wdata[CPU_DW-1:BYTE_W];

   // register file path
   assign rf_we    = cpu_wr && (region == REG_GPR);
   assign rf_addr  = cpu_addr[RF_AW-1:0];
   assign rf_wdata = wbyte;

   // external I/O path, special ports excluded
   assign io_rd    = cpu_rd && (region == REG_IO) && !is_spec;
   assign io_wr    = cpu_wr && (region == REG_IO) && !is_spec;
   assign io_addr  = IO_ADDR_W'(IO_BASE) + IO_ADDR_W'(port);
   assign io_wdata = wbyte;

   // memory path
   assign mem_rd    = cpu_rd && (region == REG_MEM);
   assign mem_wr    = cpu_wr && (region == REG_MEM);
   assign mem_addr  = cpu_addr;
   assign mem_wdata = wbyte;

   ds_special_regs #(
      .EXT_W(EXT_W)
   ) u_spec (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cpu_wr && is_spec),
      .spec_sel   (spec_sel),
      .wbyte      (wbyte),
      .cfg_page_en(cfg_page_en),
      .cfg_sp_wide(cfg_sp_wide),
      .page_q     (page_q),
      .jext_q     (jump_ext),
      .sp_q       (sp),
      .stat_q     (stat_q),
      .rd_byte    (spec_byte)
   );

   assign page_d = page_q[SPC_PAGE_D];
   assign page_x = page_q[SPC_PAGE_X];
   assign page_y = page_q[SPC_PAGE_Y];
   assign page_z = page_q[SPC_PAGE_Z];
   assign status = stat_q;

   ds_read_port u_rport (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (cpu_rd),
      .region   (region),
      .is_spec  (is_spec),
      .gpr_byte (rf_rdata),
      .io_byte  (io_rdata),
      .spec_byte(spec_byte),
      .mem_byte (mem_rdata),
      .rdata_q  (cpu_rdata),
      .rvalid_q (cpu_rvalid)
   );
endmodule

// File: rtl/ds_router_chk.sv
module ds_router_chk #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned GPR_COUNT = 32,
   parameter int unsigned IO_COUNT  = 64,
   parameter int unsigned IO_ADDR_W = 16,
   parameter int unsigned EXT_W     = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_rd,
   input logic              cpu_wr,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [7:0]        wbyte,
   input logic              page_d_en,
   input logic              cfg_sp_wide,
   input logic              rf_we,
   input logic              io_rd,
   input logic              io_wr,
   input logic [7:0]        io_wdata,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              cpu_rvalid,
   input logic [EXT_W-1:0]  page_d,
   input logic [15:0]       sp
);
   localparam logic [ADDR_W-1:0] IO_LO  = ADDR_W'(GPR_COUNT);
   localparam logic [ADDR_W-1:0] MEM_LO = ADDR_W'(GPR_COUNT + IO_COUNT);
   localparam logic [ADDR_W-1:0] A_PD   = ADDR_W'(GPR_COUNT + 'h38);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(GPR_COUNT + 'h3F);
   localparam logic [ADDR_W-1:0] A_SPL  = ADDR_W'(GPR_COUNT + 'h3D);
   localparam logic [ADDR_W-1:0] A_SPH  = ADDR_W'(GPR_COUNT + 'h3E);

   a_r1_gpr_route: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr < IO_LO) |-> (rf_we && !io_wr && !mem_wr));

   a_r3_mem_route: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr >= MEM_LO) |-> (mem_wr && !rf_we && !io_wr));

   a_r4_io_byte: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr |-> (io_wdata == wbyte));

   a_r11_special_local: assert property (@(posedge clk) disable iff (!rst_n)
      ((cpu_rd || cpu_wr) && cpu_addr >= A_PD && cpu_addr <= A_STAT)
      |-> (!io_rd && !io_wr && !mem_rd && !mem_wr && !rf_we));

   a_r6_page_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == A_PD && !page_d_en) |=> $stable(page_d));

   a_r8_sp_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == A_SPL)
      |=> ((sp[7:0] == $past(wbyte)) && (sp[15:8] == $past(sp[15:8]))));

   a_r9_sp_high_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == A_SPH && !cfg_sp_wide) |=> $stable(sp));

   a_r12_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd |=> cpu_rvalid);

   a_r12_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> !cpu_rvalid);
endmodule

bind dspace_router ds_router_chk #(
   .ADDR_W   (ADDR_W),
   .GPR_COUNT(GPR_COUNT),
   .IO_COUNT (IO_COUNT),
   .IO_ADDR_W(IO_ADDR_W),
   .EXT_W    (EXT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_rd     (cpu_rd),
   .cpu_wr     (cpu_wr),
   .cpu_addr   (cpu_addr),
   .wbyte      (cpu_wdata[7:0]),
   .page_d_en  (cfg_page_en[0]),
   .cfg_sp_wide(cfg_sp_wide),
   .rf_we      (rf_we),
   .io_rd      (io_rd),
   .io_wr      (io_wr),
   .io_wdata   (io_wdata),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .cpu_rvalid (cpu_rvalid),
   .page_d     (page_d),
   .sp         (sp)
);

// File: tb/tb_dspace_router.sv
`timescale 1ns/1ps
module tb_dspace_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_page_en = '0;
   logic        cfg_sp_wide = 1'b0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic        cpu_rvalid;
   logic        rf_we;
   logic [4:0]  rf_addr;
   logic [7:0]  rf_wdata, rf_rdata;
   logic        io_rd, io_wr;
   logic [15:0] io_addr;
   logic [7:0]  io_wdata, io_rdata;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic [23:0] page_d, page_x, page_y, page_z, jump_ext;
   logic [15:0] sp;
   logic [7:0]  status;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   // simple peripheral models
   assign rf_rdata  = {3'b000, rf_addr} ^ 8'hA0;
   assign io_rdata  = io_addr[7:0] ^ 8'h5A;
   assign mem_rdata = mem_addr[7:0] + mem_addr[15:8];

   dspace_router dut (
      .clk(clk), .rst_n(rst_n), .cfg_page_en(cfg_page_en), .cfg_sp_wide(cfg_sp_wide),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
      .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
      .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .page_d(page_d), .page_x(page_x), .page_y(page_y),
      .page_z(page_z), .jump_ext(jump_ext), .sp(sp), .status(status)
   );

   // {pad3, cfg{sp_wide,page_en[3:0]}, addr16, wdata8, expected read8, req8}
   localparam logic [47:0] VEC [14] = '{
      {3'b0, 5'b01111, 16'h0058, 8'hA5, 8'hA5, 8'd5},   // R5 D
      {3'b0, 5'b01111, 16'h0059, 8'h3C, 8'h3C, 8'd5},   // R5 X
      {3'b0, 5'b01111, 16'h005A, 8'h7E, 8'h7E, 8'd5},   // R5 Y
      {3'b0, 5'b01111, 16'h005B, 8'hC3, 8'hC3, 8'd5},   // R5 Z
      {3'b0, 5'b00000, 16'h0058, 8'h11, 8'hA5, 8'd6},   // R6 D disabled
      {3'b0, 5'b00000, 16'h005B, 8'h22, 8'hC3, 8'd6},   // R6 Z disabled
      {3'b0, 5'b00000, 16'h005C, 8'h9F, 8'h9F, 8'd7},   // R7 ungated
      {3'b0, 5'b00000, 16'h005D, 8'h34, 8'h34, 8'd8},   // R8
      {3'b0, 5'b00000, 16'h005E, 8'h12, 8'h00, 8'd9},   // R9 gated off
      {3'b0, 5'b10000, 16'h005E, 8'h12, 8'h12, 8'd9},   // R9 enabled
      {3'b0, 5'b10000, 16'h005D, 8'h78, 8'h78, 8'd8},   // R8 keeps high
      {3'b0, 5'b00000, 16'h005F, 8'h96, 8'h96, 8'd10},  // R10
      {3'b0, 5'b00001, 16'h0059, 8'h55, 8'h3C, 8'd6},   // R6 per-bit: X off
      {3'b0, 5'b00010, 16'h0059, 8'h55, 8'h55, 8'd6}    // R6 per-bit: X on
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic rd, input logic wr, input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
   endtask

   task automatic idle();
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b0;
   endtask

   task automatic read_chk(input logic [15:0] a, input logic [7:0] exp, input string req);
      drive(1'b1, 1'b0, a, 16'h0);
      idle();
      check({req, " rvalid"}, {31'b0, cpu_rvalid}, 32'd1);
      check({req, " rdata"}, {24'b0, cpu_rdata}, {24'b0, exp});
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog act=timeout exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R13 reset state
      check("R13 rvalid", {31'b0, cpu_rvalid}, 32'd0);
      check("R13 page_d", {8'b0, page_d}, 32'd0);
      check("R13 jump_ext", {8'b0, jump_ext}, 32'd0);
      check("R13 sp", {16'b0, sp}, 32'd0);
      check("R13 status", {24'b0, status}, 32'd0);
      rst_n = 1'b1;

      // table of special-register write/read vectors
      for (int i = 0; i < 14; i++) begin
         logic [47:0] v;
         string tag;
         v = VEC[i];
         tag = $sformatf("R%0d vec%0d", v[7:0], i);
         @(negedge clk);
         cfg_sp_wide = v[44];
         cfg_page_en = v[43:40];
         drive(1'b0, 1'b1, v[39:24], {8'hEE, v[23:16]});
         idle();
         read_chk(v[39:24], v[15:8], tag);
      end
      check("R5 page_d word", {8'b0, page_d}, 32'h00A50000);
      check("R6 page_x word", {8'b0, page_x}, 32'h00550000);
      check("R5 page_y word", {8'b0, page_y}, 32'h007E0000);
      check("R6 page_z word", {8'b0, page_z}, 32'h00C30000);
      check("R7 jump_ext word", {8'b0, jump_ext}, 32'h009F0000);
      check("R8 sp word", {16'b0, sp}, 32'h1278);
      check("R10 status flags", {24'b0, status}, 32'h96);

      // R1 register file, R4 byte masking
      drive(1'b0, 1'b1, 16'd5, 16'hAB77);
      #1;
      check("R1 rf_we", {31'b0, rf_we}, 32'd1);
      check("R1 rf_addr", {27'b0, rf_addr}, 32'd5);
      check("R4 rf_wdata", {24'b0, rf_wdata}, 32'h77);
      check("R1 no io/mem", {30'b0, io_wr, mem_wr}, 32'd0);
      idle();
      read_chk(16'd31, 8'hBF, "R1 read top gpr");

      // R2 I/O bus
      drive(1'b0, 1'b1, 16'd32, 16'h5511);
      #1;
      check("R2 io_wr", {31'b0, io_wr}, 32'd1);
      check("R2 io_addr low", {16'b0, io_addr}, 32'h0020);
      check("R4 io_wdata", {24'b0, io_wdata}, 32'h11);
      check("R2 no rf/mem", {30'b0, rf_we, mem_wr}, 32'd0);
      idle();
      drive(1'b0, 1'b1, 16'h0057, 16'h0042);
      #1;
      check("R2 io_addr last", {16'b0, io_addr}, 32'h0057);
      idle();
      read_chk(16'h0057, 8'h0D, "R2 io read");

      // R3 memory
      drive(1'b0, 1'b1, 16'd96, 16'hFF3A);
      #1;
      check("R3 mem_wr", {31'b0, mem_wr}, 32'd1);
      check("R3 mem_addr", {16'b0, mem_addr}, 32'd96);
      check("R4 mem_wdata", {24'b0, mem_wdata}, 32'h3A);
      check("R3 no rf/io", {30'b0, rf_we, io_wr}, 32'd0);
      idle();
      read_chk(16'h1234, 8'h46, "R3 mem read");

      // R11 special ports stay local
      drive(1'b1, 1'b1, 16'h005C, 16'h0001);
      #1;
      check("R11 no strobes", {27'b0, rf_we, io_rd, io_wr, mem_rd, mem_wr}, 32'd0);
      idle();

      // R12 read and write of SP low in the same cycle
      drive(1'b1, 1'b1, 16'h005D, 16'h00EE);
      idle();
      check("R12 same-cycle rvalid", {31'b0, cpu_rvalid}, 32'd1);
      check("R12 same-cycle old value", {24'b0, cpu_rdata}, 32'h78);
      read_chk(16'h005D, 8'hEE, "R12 new value");
      check("R8 sp after overlap", {16'b0, sp}, 32'h12EE);
      @(negedge clk);
      check("R12 rvalid drops", {31'b0, cpu_rvalid}, 32'd0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule